// File: doc/BRIEF.md
# Configurable Audio Serial Receiver

This block turns a serial audio stream into parallel words. It runs on the bit clock that arrives with the stream. On each rising edge it samples the data line and the word-select line. A change on word-select marks the boundary between two slots, and the level of word-select during a slot gives that slot's channel.

Within each slot the receiver finds the sample from four settings:
- the slot-start delay mode;
- whether padding comes before or after the data;
- the data word length;
- the slot length.

It drops the padding and moves the sample into a 32-bit output word. Wide samples are justified in one direction or the other. Narrow samples are packed several to a word. Finished words leave over a valid/ready handshake, each with a channel tag.

If the consumer has not taken the previous word when a new word finishes, the new word is discarded and a one-cycle overflow pulse is raised. Capture starts only at a slot start seen while enabled, so the first captured slot is always a complete slot.

Top module: `audio_ser_rx`

## Requirements
- R1: While reset is high and on the cycle after it, `out_valid` and `overflow` are 0 and `out_data` is 0.
- R2: With `delay_mode`=0, the first bit of a slot is the bit sampled one rising edge after the edge at which a word-select change is first seen. With `delay_mode`=1, it is the bit sampled at that same edge.
- R3: Slot length is 8*(`swl_sel`+1) bits. With `align_tail`=0, the sample occupies the first N bits of the slot. With `align_tail`=1, it occupies the last N bits. All other slot bits are ignored whatever their value.
- R4: Bits are sampled on the rising clock edge and assembled MSB first. `out_chan` equals the word-select level during the slot (0 for low). For a packed word, it is the level during the first slot packed into that word.
- R5: `dwl_sel` 2, 3, 4 and 5 select 18, 20, 22 and 24 data bits. With `alloc`=0 the sample sits in the top bits of `out_data`. With `alloc`=1 it sits in the bottom bits. All other bits are zero.
- R6: `dwl_sel` 0 and 1 select 8 and 16 data bits, packed four or two samples per word. With `alloc`=0 the first sample fills bits [N-1:0] and later samples fill successively higher lanes. With `alloc`=1 the first sample fills the top lane and later samples fill successively lower lanes.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_chan` hold. A word transfers on a rising edge at which both are high.
- R8: A word that finishes while the previous word is still pending is discarded. `overflow` is then high for exactly one cycle.
- R9: While `rx_en` is low, no word is produced. After `rx_en` rises, capture begins with the next slot start. A slot already in progress is skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; data and word-select sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | Word-select; a change marks a slot boundary, its level gives the channel |
| sd | input | 1 | Serial data line |
| rx_en | input | 1 | Receive enable |
| dwl_sel | input | 3 | Data word length code (0:8, 1:16, 2:18, 3:20, 4:22, 5:24) |
| swl_sel | input | 2 | Slot length code, 8*(code+1) bits |
| delay_mode | input | 1 | 0: one-bit delay after the slot boundary, 1: no delay |
| align_tail | input | 1 | 0: data then padding, 1: padding then data |
| alloc | input | 1 | Packing or justification select |
| out_ready | input | 1 | Consumer ready |
| out_valid | output | 1 | Output word valid |
| out_data | output | OUT_W | Parallel output word |
| out_chan | output | 1 | Channel tag of the output word |
| overflow | output | 1 | One-cycle pulse when a finished word is dropped |

## Verification
The hardest cases to reach from the ports are an enable that rises partway through a slot and a consumer that stalls while further words finish.

The bench builds whole frame streams bit by bit from the requirements and sweeps every legal combination of data length, slot length, delay mode, alignment and allocation. Padding bits are set to non-zero patterns, so a padding bit that leaks into the data shows up in the result.

Separate runs cover three further cases:
- `rx_en` raised in the middle of a slot;
- `rx_en` kept low for a whole run;
- `out_ready` held low across a full frame sequence, with the overflow pulses counted and the held word checked once it is released.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  // Data word length in bits for a length code.
  function automatic int dwl_bits(input logic [2:0] sel);
    case (sel)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 18;
      3'd3:    return 20;
      3'd4:    return 22;
      default: return 24;
    endcase
  endfunction

  // Slot length in bits for a slot code.
  function automatic int swl_bits(input logic [1:0] sel);
    return 8 * (int'(sel) + 1);
  endfunction

endpackage

// File: rtl/asrx_slot_track.sv
module asrx_slot_track #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ws,
  input  logic             delay_mode,
  output logic             start,
  output logic [CNT_W-1:0] idx,
  output logic             chan
);
  logic             ws_q, ws_seen, edge_q, chan_q;
  logic [CNT_W-1:0] cnt;
  logic             edge_now;

  assign edge_now = ws_seen && (ws != ws_q);
  assign start    = delay_mode ? edge_now : edge_q;
  assign idx      = start ? '0 : cnt;
  assign chan     = start ? ws : chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q    <= 1'b0;
      ws_seen <= 1'b0;
      edge_q  <= 1'b0;
      chan_q  <= 1'b0;
      cnt     <= '0;
    end else begin
      ws_q    <= ws;
      ws_seen <= 1'b1;
      edge_q  <= edge_now;
      chan_q  <= chan;
      if (idx != '1) cnt <= idx + 1'b1;
      else           cnt <= idx;
    end
  end
endmodule

// File: rtl/asrx_bit_capture.sv
module asrx_bit_capture
  import asrx_pkg::*;
#(
  parameter int DATA_MAX = 24,
  parameter int CNT_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic [CNT_W-1:0]    idx,
  input  logic                sd,
  input  logic [2:0]          dwl_sel,
  input  logic [1:0]          swl_sel,
  input  logic                align_tail,
  output logic                done,
  output logic [DATA_MAX-1:0] sample
);
  logic [DATA_MAX-1:0] sh;
  logic [CNT_W-1:0]    dn, sn, first, last;
  logic                in_data;

  always_comb begin
    dn      = CNT_W'(dwl_bits(dwl_sel));
    sn      = CNT_W'(swl_bits(swl_sel));
    first   = align_tail ? (sn - dn) : '0;
    last    = first + dn - 1'b1;
    in_data = (idx >= first) && (idx <= last);
  end

  assign sample = {sh[DATA_MAX-2:0], sd};
  assign done   = active && (idx == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (active && in_data) begin
      if (idx == first) sh <= {{(DATA_MAX-1){1'b0}}, sd};
      else              sh <= sample;
    end
  end
endmodule

// File: rtl/asrx_pack.sv
module asrx_pack
  import asrx_pkg::*;
#(
  parameter int OUT_W    = 32,
  parameter int DATA_MAX = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic                done,
  input  logic [DATA_MAX-1:0] sample,
  input  logic                chan,
  input  logic [2:0]          dwl_sel,
  input  logic                alloc,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_chan,
  output logic                overflow
);
  logic [1:0]       pk;
  logic [OUT_W-1:0] acc, ext, base, merged, word;
  logic             acc_chan, wchan, narrow, last;
  int               dn, lanes, pos;

  always_comb begin
    dn     = dwl_bits(dwl_sel);
    narrow = (dwl_sel < 3'd2);
    lanes  = narrow ? (OUT_W / dn) : 1;
    pos    = alloc ? (lanes - 1 - int'(pk)) : int'(pk);
    ext    = OUT_W'(sample);
    base   = (pk == 2'd0) ? '0 : acc;
    merged = base | (ext << (pos * dn));
    last   = (int'(pk) == lanes - 1);
    word   = narrow ? merged : (alloc ? ext : (ext << (OUT_W - dn)));
    wchan  = (narrow && pk != 2'd0) ? acc_chan : chan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pk        <= '0;
      acc       <= '0;
      acc_chan  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      overflow <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (!active) begin
        pk <= '0;
      end else if (done) begin
        if (!last) begin
          acc      <= merged;
          acc_chan <= wchan;
          pk       <= pk + 2'd1;
        end else begin
          pk <= '0;
          if (out_valid && !out_ready) begin
            overflow <= 1'b1;
          end else begin
            out_valid <= 1'b1;
            out_data  <= word;
            out_chan  <= wchan;
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_ser_rx.sv
module audio_ser_rx #(
  parameter int OUT_W    = 32,
  parameter int DATA_MAX = 24,
  parameter int SLOT_MAX = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ws,
  input  logic             sd,
  input  logic             rx_en,
  input  logic [2:0]       dwl_sel,
  input  logic [1:0]       swl_sel,
  input  logic             delay_mode,
  input  logic             align_tail,
  input  logic             alloc,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_chan,
  output logic             overflow
);
  localparam int CNT_W = $clog2(SLOT_MAX) + 2;

  logic             start, chan, armed, active, done;
  logic [CNT_W-1:0] idx;
  logic [DATA_MAX-1:0] sample;

  // Capture only from a slot start seen while enabled.
  assign active = rx_en && (armed || start);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= active;
  end

  asrx_slot_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .ws(ws), .delay_mode(delay_mode),
    .start(start), .idx(idx), .chan(chan)
  );

  asrx_bit_capture #(.DATA_MAX(DATA_MAX), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .active(active), .idx(idx), .sd(sd),
    .dwl_sel(dwl_sel), .swl_sel(swl_sel), .align_tail(align_tail),
    .done(done), .sample(sample)
  );

  asrx_pack #(.OUT_W(OUT_W), .DATA_MAX(DATA_MAX)) u_pack (
    .clk(clk), .rst(rst), .active(active), .done(done), .sample(sample),
    .chan(chan), .dwl_sel(dwl_sel), .alloc(alloc), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan),
    .overflow(overflow)
  );
endmodule

// File: rtl/asrx_checker.sv
module asrx_checker #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic [2:0]       dwl_sel,
  input logic             alloc,
  input logic             out_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             out_chan,
  input logic             overflow
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !overflow));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past(out_valid) && !$past(out_ready)));

  p_ovf_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> !overflow);

  p_enable_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(rx_en));

  p_rjust_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && alloc && dwl_sel >= 3'd2 && dwl_sel <= 3'd5) |-> (out_data[OUT_W-1:24] == '0));
endmodule

bind audio_ser_rx asrx_checker #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .dwl_sel(dwl_sel), .alloc(alloc),
  .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
  .out_chan(out_chan), .overflow(overflow)
);

// File: tb/audio_ser_rx_test.sv
module audio_ser_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ws = 1'b1, sd = 1'b0, rx_en = 1'b0;
  logic [2:0]  dwl_sel = 3'd0;
  logic [1:0]  swl_sel = 2'd0;
  logic        delay_mode = 1'b0, align_tail = 1'b0, alloc = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid, out_chan, overflow;
  logic [31:0] out_data;

  int checks = 0, errors = 0, cycles = 0;
  int got_n = 0, ovf_n = 0;
  logic [31:0] got_d [0:63];
  logic        got_c [0:63];
  logic        bw [0:399];
  logic        bs [0:399];

  localparam int M = 8;

  always #5 clk = ~clk;

  audio_ser_rx uut (
    .clk(clk), .rst(rst), .ws(ws), .sd(sd), .rx_en(rx_en),
    .dwl_sel(dwl_sel), .swl_sel(swl_sel), .delay_mode(delay_mode),
    .align_tail(align_tail), .alloc(alloc), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan),
    .overflow(overflow)
  );

  // Monitor: sample after the driver has settled for the coming edge.
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (out_valid && out_ready && got_n < 64) begin
        got_d[got_n] = out_data;
        got_c[got_n] = out_chan;
        got_n++;
      end
      if (overflow) ovf_n++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected < 200000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int dlen(input int s);
    case (s) 0: return 8; 1: return 16; 2: return 18; 3: return 20; 4: return 22; default: return 24; endcase
  endfunction

  function automatic logic [31:0] sval(input int s, input int cfg, input int dn);
    logic [31:0] v;
    v = (32'(s) * 32'd40503 + 32'(cfg) * 32'd977 + 32'd12345) ^ (32'(s) << 13) ^ 32'h00A5_5A00;
    return v & ((32'd1 << dn) - 32'd1);
  endfunction

  function automatic logic slot_ch(input int s);
    return (s == 0) ? 1'b1 : 1'(((s - 1) % 2));
  endfunction

  // en_slot: 0 enabled from start, k>0 raised mid-slot k, -1 never.
  task automatic run(input int ds, input int ss, input bit dly, input bit aln,
                     input bit alc, input int en_slot, input bit stall);
    int dn, sn, f, cfg, nl, nw, nsamp;
    logic [31:0] exp_d [0:15];
    logic        exp_c [0:15];
    string tag;
    dn  = dlen(ds);
    sn  = 8 * (ss + 1);
    cfg = ds * 64 + ss * 8 + dly * 4 + aln * 2 + alc;
    @(negedge clk); #1;
    rst = 1'b1; rx_en = (en_slot == 0); out_ready = !stall; ws = 1'b1; sd = 1'b0;
    dwl_sel = 3'(ds); swl_sel = 2'(ss); delay_mode = dly; align_tail = aln; alloc = alc;
    repeat (3) @(negedge clk);
    #1; rst = 1'b0; got_n = 0; ovf_n = 0;
    for (int s = 0; s < M + 2; s++) begin
      logic [31:0] v;
      v = sval(s, cfg, dn);
      for (int k = 0; k < sn; k++) begin
        int i;
        i = s * sn + k;
        bw[i] = slot_ch(s);
        if (!aln && k < dn)              bs[i] = v[dn - 1 - k];
        else if (aln && k >= sn - dn)    bs[i] = v[dn - 1 - (k - (sn - dn))];
        else                             bs[i] = ~k[0];
      end
    end
    for (int i = 0; i < (M + 1) * sn; i++) begin
      if (en_slot > 0 && i == en_slot * sn + sn / 2) rx_en = 1'b1;
      ws = dly ? bw[i] : bw[i + 1];
      sd = bs[i];
      @(negedge clk); #1;
    end
    rx_en = 1'b0;
    repeat (4) @(negedge clk);
    #1; out_ready = 1'b1;
    repeat (4) @(negedge clk);

    // Expected words computed from the requirements.
    nw = 0;
    if (en_slot >= 0) begin
      f = (en_slot == 0) ? 1 : en_slot + 1;
      nsamp = M - f + 1;
      nl = (ds < 2) ? 32 / dn : 1;
      for (int w = 0; w < nsamp / nl; w++) begin
        logic [31:0] acc;
        acc = 32'd0;
        for (int q = 0; q < nl; q++) begin
          logic [31:0] v;
          int p;
          v = sval(f + w * nl + q, cfg, dn);
          if (ds < 2) begin
            p = alc ? (nl - 1 - q) : q;
            acc = acc | (v << (p * dn));
          end else begin
            acc = alc ? v : (v << (32 - dn));
          end
        end
        exp_d[w] = acc;
        exp_c[w] = slot_ch(f + w * nl);
        nw++;
      end
    end
    tag = (ds < 2) ? "R2 R3 R4 R6" : "R2 R3 R4 R5";
    if (stall) begin
      chk(got_n == 1, "R7 words after stall", 32'(got_n), 32'd1);
      chk(ovf_n == nw - 1, "R8 overflow pulses", 32'(ovf_n), 32'(nw - 1));
      if (got_n >= 1) begin
        chk(got_d[0] == exp_d[0], "R7 held word data", got_d[0], exp_d[0]);
        chk(got_c[0] == exp_c[0], "R7 held word chan", 32'(got_c[0]), 32'(exp_c[0]));
      end
    end else begin
      chk(got_n == nw, (en_slot != 0) ? "R9 word count" : "R3 word count", 32'(got_n), 32'(nw));
      chk(ovf_n == 0, "R8 no overflow when ready", 32'(ovf_n), 32'd0);
      for (int w = 0; w < nw && w < got_n; w++) begin
        chk(got_d[w] == exp_d[w], (en_slot > 0) ? "R9 data" : tag, got_d[w], exp_d[w]);
        chk(got_c[w] == exp_c[w], "R4 channel tag", 32'(got_c[w]), 32'(exp_c[w]));
      end
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk(overflow == 1'b0, "R1 overflow in reset", 32'(overflow), 32'd0);
    chk(out_data == 32'd0, "R1 out_data in reset", out_data, 32'd0);

    // Sweep every legal configuration (R2..R6).
    for (int ds = 0; ds < 6; ds++)
      for (int ss = 0; ss < 4; ss++)
        if (8 * (ss + 1) >= dlen(ds))
          for (int m = 0; m < 8; m++)
            run(ds, ss, m[2], m[1], m[0], 0, 1'b0);

    // R9: enable raised mid-slot, both delay modes; and never enabled.
    run(5, 3, 1'b0, 1'b0, 1'b0, 2, 1'b0);
    run(5, 3, 1'b1, 1'b1, 1'b1, 3, 1'b0);
    run(3, 2, 1'b1, 1'b0, 1'b0, -1, 1'b0);

    // R7, R8: consumer stalled for the whole run.
    run(5, 3, 1'b1, 1'b0, 1'b0, 0, 1'b1);
    run(2, 2, 1'b0, 1'b1, 1'b1, 0, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule